// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the central hazard tracker of a small out-of-order floating-point engine. Instructions arrive in program order on a decode port that carries an operation class, a destination register and two source registers. The controller picks a free functional unit of the right class and records the instruction in that unit's status slot. It then decides when the unit may read its operands, counts the unit's execution latency, and decides when the unit may write its result back. Per-unit start and write-back grants go out to the datapath. The datapath itself and the register file contents are not part of this block.

Each slot holds a busy flag, the destination register, both source register numbers, the producing unit for each source and a ready flag for each source. A per-register owner table records which unit will write each register next. There is no forwarding. A consumer waits until its producer has written back before it reads. Issue stalls on a busy unit class and on a pending writer of the same destination. A finished unit is held back from write-back while an older instruction still needs the register's old value. Issue is in order, while execution and completion may happen out of order.

Top module: `sb_issue_ctrl`

## Requirements
- R1: During and right after reset, no unit is busy, `start_o` and `wb_o` are all zero, and `dec_ready_o` is high for any instruction whose registers are free.
- R2: Operation class codes are 0 integer, 1 multiply, 2 add and 3 divide. Unit 0 is the integer unit, units 1..NUM_MUL are multipliers, then comes the adder, then the divider. An issued instruction goes to the lowest-numbered free unit of its class, and `issue_fu_o` reports that unit in the issue cycle.
- R3: When every unit of the requested class is busy, `dec_ready_o` is low and the instruction is held. It issues in the first cycle after a unit of that class has written back.
- R4: When the destination register is owned by an unfinished unit, issue stalls. It resumes in the cycle after that owner writes back.
- R5: A unit raises its `start_o` bit for exactly one cycle, and only when both of its sources are ready. With free sources this is the cycle after issue. With a pending producer it is the cycle after that producer's write-back.
- R6: A unit whose `start_o` is high in cycle S may receive its write-back grant no earlier than cycle S+LAT+1, where LAT is the unit class latency (defaults 1 integer, 4 multiply, 2 add, 8 divide). It receives the grant then if nothing blocks it.
- R7: A finished unit is not granted write-back while another unit still has a ready, not-yet-read source that names the finished unit's destination register.
- R8: At most one `wb_o` bit is high per cycle. Among the eligible units, the lowest-numbered one wins.
- R9: A write-back frees the unit and the register owner entry at the next clock edge. An instruction issuing in the same cycle as that write-back, and sourcing the register being written, treats that source as ready.
- R10: An instruction whose unit and destination are free issues in the cycle it is presented, so instructions can issue back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode port holds an instruction |
| dec_op_i | input | 2 | Operation class (0 int, 1 mul, 2 add, 3 div) |
| dec_dst_i | input | $clog2(NUM_REGS) | Destination register |
| dec_src1_i | input | $clog2(NUM_REGS) | First source register |
| dec_src2_i | input | $clog2(NUM_REGS) | Second source register |
| dec_ready_o | output | 1 | Presented instruction can issue this cycle |
| issue_fu_o | output | $clog2(NUM_MUL+4) | Unit chosen for the presented instruction |
| start_o | output | NUM_MUL+3 | Per-unit operand read and execute start |
| wb_o | output | NUM_MUL+3 | Per-unit write-back grant |

## Verification
The bench targets the timing of each hazard rule. A structural stall must release exactly when a multiplier frees, or the third multiply would issue early or land in the wrong unit. A destination conflict must stall until the owner retires, or two units would end up owning one register. A write-after-read case holds a fast integer result behind a slow divide feeding an adder. A design that ignores the old reader writes back at cycle +5 instead of +12. Two further cases cover the arbiter tie, where an inverted priority swaps the write-back order, and an instruction issuing in the very cycle its producer writes back. Without the bypass that instruction waits forever and trips the watchdog.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OP_INT = 2'd0,
    OP_MUL = 2'd1,
    OP_ADD = 2'd2,
    OP_DIV = 2'd3
  } op_e;
endpackage

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int N  = 5,
  parameter int UW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [UW-1:0] idx_o,
  output logic          any_o
);
  // scan downward so the lowest requester is the last to be written
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = UW'(i);
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot #(
  parameter int RW   = 3,
  parameter int UW   = 3,
  parameter int CW   = 4,
  parameter int LAT  = 1,
  parameter int NONE = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [RW-1:0] fi_i,
  input  logic [RW-1:0] fj_i,
  input  logic [RW-1:0] fk_i,
  input  logic [UW-1:0] qj_i,
  input  logic [UW-1:0] qk_i,
  input  logic          rj_i,
  input  logic          rk_i,
  input  logic          wb_valid_i,
  input  logic [UW-1:0] wb_unit_i,
  input  logic          wb_grant_i,
  output logic          busy_o,
  output logic          start_o,
  output logic          done_o,
  output logic [RW-1:0] fi_o,
  output logic [RW-1:0] fj_o,
  output logic [RW-1:0] fk_o,
  output logic          rj_o,
  output logic          rk_o
);
  logic          busy_q, run_q, done_q, rj_q, rk_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] fi_q, fj_q, fk_q;
  logic [UW-1:0] qj_q, qk_q;

  assign start_o = busy_q & rj_q & rk_q & ~run_q & ~done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      fi_q   <= '0;
      fj_q   <= '0;
      fk_q   <= '0;
      qj_q   <= UW'(NONE);
      qk_q   <= UW'(NONE);
      rj_q   <= 1'b0;
      rk_q   <= 1'b0;
    end else if (issue_i) begin
      busy_q <= 1'b1;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      fi_q   <= fi_i;
      fj_q   <= fj_i;
      fk_q   <= fk_i;
      qj_q   <= qj_i;
      qk_q   <= qk_i;
      rj_q   <= rj_i;
      rk_q   <= rk_i;
    end else begin
      if (wb_valid_i && qj_q == wb_unit_i) begin
        rj_q <= 1'b1;
        qj_q <= UW'(NONE);
      end
      if (wb_valid_i && qk_q == wb_unit_i) begin
        rk_q <= 1'b1;
        qk_q <= UW'(NONE);
      end
      // operands consumed: drop flags so writers of fj/fk are no longer held
      if (start_o) begin
        rj_q  <= 1'b0;
        rk_q  <= 1'b0;
        run_q <= 1'b1;
        cnt_q <= CW'(LAT);
      end
      if (run_q) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
      if (wb_grant_i) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign fi_o   = fi_q;
  assign fj_o   = fj_q;
  assign fk_o   = fk_q;
  assign rj_o   = rj_q;
  assign rk_o   = rk_q;

  // R3
  issue_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !busy_q);
  // R5
  start_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R6
  grant_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_grant_i |-> done_q);
  // R9
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_grant_i |=> !busy_q);
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int NUM_MUL  = 2,
  parameter int LAT_INT  = 1,
  parameter int LAT_MUL  = 4,
  parameter int LAT_ADD  = 2,
  parameter int LAT_DIV  = 8,
  localparam int NUM_FU  = NUM_MUL + 3,
  localparam int RW      = $clog2(NUM_REGS),
  localparam int UW      = $clog2(NUM_FU + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_valid_i,
  input  logic [1:0]        dec_op_i,
  input  logic [RW-1:0]     dec_dst_i,
  input  logic [RW-1:0]     dec_src1_i,
  input  logic [RW-1:0]     dec_src2_i,
  output logic              dec_ready_o,
  output logic [UW-1:0]     issue_fu_o,
  output logic [NUM_FU-1:0] start_o,
  output logic [NUM_FU-1:0] wb_o
);
  localparam int NONE    = NUM_FU;
  localparam int LAT_M1  = (LAT_INT > LAT_MUL) ? LAT_INT : LAT_MUL;
  localparam int LAT_M2  = (LAT_ADD > LAT_DIV) ? LAT_ADD : LAT_DIV;
  localparam int LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
  localparam int CW      = $clog2(LAT_MAX + 1);

  function automatic op_e unit_op(input int u);
    if (u == 0) return OP_INT;
    if (u <= NUM_MUL) return OP_MUL;
    if (u == NUM_MUL + 1) return OP_ADD;
    return OP_DIV;
  endfunction

  function automatic int unit_lat(input int u);
    if (u == 0) return LAT_INT;
    if (u <= NUM_MUL) return LAT_MUL;
    if (u == NUM_MUL + 1) return LAT_ADD;
    return LAT_DIV;
  endfunction

  logic [UW-1:0]     owner_q [NUM_REGS];
  logic [NUM_FU-1:0] busy, done, rj, rk, war, wb_req, issue_en;
  logic [RW-1:0]     fi [NUM_FU];
  logic [RW-1:0]     fj [NUM_FU];
  logic [RW-1:0]     fk [NUM_FU];
  logic [UW-1:0]     sel, wb_idx, own1, own2, qj_n, qk_n;
  logic              found, wb_any, fire;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int u = NUM_FU - 1; u >= 0; u--) begin
      if (!busy[u] && unit_op(u) == op_e'(dec_op_i)) begin
        sel   = UW'(u);
        found = 1'b1;
      end
    end
  end

  assign dec_ready_o = found && owner_q[dec_dst_i] == UW'(NONE);
  assign fire        = dec_valid_i && dec_ready_o;
  assign issue_fu_o  = sel;

  // source being written back this very cycle counts as ready
  assign own1 = owner_q[dec_src1_i];
  assign own2 = owner_q[dec_src2_i];
  assign qj_n = (wb_any && own1 == wb_idx) ? UW'(NONE) : own1;
  assign qk_n = (wb_any && own2 == wb_idx) ? UW'(NONE) : own2;

  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      war[u] = 1'b0;
      for (int g = 0; g < NUM_FU; g++) begin
        if (g != u && ((fj[g] == fi[u] && rj[g]) || (fk[g] == fi[u] && rk[g])))
          war[u] = 1'b1;
      end
      wb_req[u]   = done[u] & ~war[u];
      issue_en[u] = fire && sel == UW'(u);
    end
  end

  sb_wb_arb #(.N(NUM_FU), .UW(UW)) u_arb (
    .req_i (wb_req),
    .gnt_o (wb_o),
    .idx_o (wb_idx),
    .any_o (wb_any)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
    sb_fu_slot #(
      .RW(RW), .UW(UW), .CW(CW), .LAT(unit_lat(u)), .NONE(NONE)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .issue_i    (issue_en[u]),
      .fi_i       (dec_dst_i),
      .fj_i       (dec_src1_i),
      .fk_i       (dec_src2_i),
      .qj_i       (qj_n),
      .qk_i       (qk_n),
      .rj_i       (qj_n == UW'(NONE)),
      .rk_i       (qk_n == UW'(NONE)),
      .wb_valid_i (wb_any),
      .wb_unit_i  (wb_idx),
      .wb_grant_i (wb_o[u]),
      .busy_o     (busy[u]),
      .start_o    (start_o[u]),
      .done_o     (done[u]),
      .fi_o       (fi[u]),
      .fj_o       (fj[u]),
      .fk_o       (fk[u]),
      .rj_o       (rj[u]),
      .rk_o       (rk[u])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) owner_q[r] <= UW'(NONE);
    end else begin
      for (int r = 0; r < NUM_REGS; r++)
        if (wb_any && owner_q[r] == wb_idx) owner_q[r] <= UW'(NONE);
      if (fire) owner_q[dec_dst_i] <= sel;
    end
  end

  // R8
  wb_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wb_o));
  // R4
  owner_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> owner_q[$past(dec_dst_i)] == $past(sel));
endmodule

// File: tb/tb_sb_issue_ctrl.sv
module tb_sb_issue_ctrl;
  localparam int NFU = 5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dec_valid_i = 1'b0;
  logic [1:0] dec_op_i = '0;
  logic [2:0] dec_dst_i = '0, dec_src1_i = '0, dec_src2_i = '0;
  logic       dec_ready_o;
  logic [2:0] issue_fu_o;
  logic [NFU-1:0] start_o, wb_o;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  typedef struct {
    int    unit;
    int    cyc;
    string tag;
  } ev_t;
  ev_t sq[$];
  ev_t wq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sb_issue_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .dec_valid_i(dec_valid_i), .dec_op_i(dec_op_i),
    .dec_dst_i(dec_dst_i), .dec_src1_i(dec_src1_i), .dec_src2_i(dec_src2_i),
    .dec_ready_o(dec_ready_o), .issue_fu_o(issue_fu_o), .start_o(start_o), .wb_o(wb_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic exp_start(input int u, input int c, input string tag);
    ev_t e;
    e.unit = u; e.cyc = c; e.tag = tag;
    sq.push_back(e);
  endtask

  task automatic exp_wb(input int u, input int c, input string tag);
    ev_t e;
    e.unit = u; e.cyc = c; e.tag = tag;
    wq.push_back(e);
  endtask

  // monitor: pop expected events, encoded as unit*1000+cycle
  always @(negedge clk) begin
    if (rst_ni) begin
      for (int u = 0; u < NFU; u++) begin
        if (start_o[u]) begin
          if (sq.size() == 0) chk("R5 unexpected start", u * 1000 + cyc, -1);
          else begin
            ev_t e;
            e = sq.pop_front();
            chk(e.tag, u * 1000 + cyc, e.unit * 1000 + e.cyc);
          end
        end
        if (wb_o[u]) begin
          if (wq.size() == 0) chk("R8 unexpected wb", u * 1000 + cyc, -1);
          else begin
            ev_t e;
            e = wq.pop_front();
            chk(e.tag, u * 1000 + cyc, e.unit * 1000 + e.cyc);
          end
        end
      end
    end
  end

  // called just after a negedge; returns issue cycle with valid still high
  task automatic send(input int op, input int dst, input int s1, input int s2,
                      output int icyc, output int fu);
    dec_valid_i = 1'b1;
    dec_op_i    = 2'(op);
    dec_dst_i   = 3'(dst);
    dec_src1_i  = 3'(s1);
    dec_src2_i  = 3'(s2);
    #1;
    while (!dec_ready_o) begin
      @(negedge clk);
      #1;
    end
    icyc = cyc;
    fu   = int'(issue_fu_o);
  endtask

  task automatic hold_done();
    @(negedge clk);
    #1;
    dec_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (sq.size() != 0 || wq.size() != 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    int i1, i2, i3, f;
    repeat (3) @(negedge clk);
    chk("R1 start in reset", int'(start_o), 0);
    chk("R1 wb in reset", int'(wb_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 ready after reset", int'(dec_ready_o), 1);

    // independent integer op
    send(0, 1, 2, 3, i1, f);
    chk("R2 int unit", f, 0);
    exp_start(0, i1 + 1, "R5 free-source start");
    exp_wb(0, i1 + 3, "R6 int latency");
    hold_done();
    drain();

    // RAW: add waits for multiply
    send(1, 4, 1, 2, i1, f);
    chk("R2 first mul", f, 1);
    exp_start(1, i1 + 1, "R5 mul start");
    exp_wb(1, i1 + 6, "R6 mul latency");
    hold_done();
    send(2, 5, 4, 1, i2, f);
    chk("R10 back to back", i2, i1 + 1);
    exp_start(3, i1 + 7, "R5 start after producer wb");
    exp_wb(3, i1 + 10, "R6 add latency");
    hold_done();
    drain();

    // structural: three multiplies on two units
    send(1, 1, 0, 0, i1, f);
    exp_start(1, i1 + 1, "R5 mul a start");
    exp_wb(1, i1 + 6, "R6 mul a wb");
    hold_done();
    send(1, 2, 0, 0, i2, f);
    chk("R2 second mul", f, 2);
    exp_start(2, i1 + 2, "R5 mul b start");
    exp_wb(2, i1 + 7, "R6 mul b wb");
    hold_done();
    send(1, 3, 0, 0, i3, f);
    chk("R3 structural stall release", i3, i1 + 7);
    chk("R2 reuse lowest mul", f, 1);
    exp_start(1, i1 + 8, "R5 mul c start");
    exp_wb(1, i1 + 13, "R6 mul c wb");
    hold_done();
    drain();

    // WAW on r6
    send(2, 6, 0, 0, i1, f);
    exp_start(3, i1 + 1, "R5 add start");
    exp_wb(3, i1 + 4, "R6 add wb");
    hold_done();
    send(0, 6, 0, 0, i2, f);
    chk("R4 waw stall release", i2, i1 + 5);
    exp_start(0, i1 + 6, "R5 int start");
    exp_wb(0, i1 + 8, "R9 int wb after waw");
    hold_done();
    drain();

    // WAR: int writing r2 must wait for add reading r2
    send(3, 1, 0, 0, i1, f);
    chk("R2 div unit", f, 4);
    exp_start(4, i1 + 1, "R5 div start");
    exp_wb(4, i1 + 10, "R6 div latency");
    hold_done();
    send(2, 3, 1, 2, i2, f);
    hold_done();
    send(0, 2, 0, 0, i3, f);
    chk("R10 third issue", i3, i1 + 2);
    exp_start(0, i1 + 3, "R5 int start");
    exp_start(3, i1 + 11, "R5 add waits for div");
    exp_wb(0, i1 + 12, "R7 war held write-back");
    exp_wb(3, i1 + 14, "R6 add wb");
    hold_done();
    drain();

    // tie: adder and int done together
    send(2, 2, 0, 0, i1, f);
    exp_start(3, i1 + 1, "R5 add start");
    hold_done();
    send(0, 3, 0, 0, i2, f);
    exp_start(0, i1 + 2, "R5 int start");
    exp_wb(0, i1 + 4, "R8 lowest wins tie");
    exp_wb(3, i1 + 5, "R8 loser next cycle");
    hold_done();
    drain();

    // issue in the same cycle the producer writes back
    send(0, 4, 0, 0, i1, f);
    exp_start(0, i1 + 1, "R5 int start");
    exp_wb(0, i1 + 3, "R6 int wb");
    hold_done();
    @(negedge clk);
    @(negedge clk);
    #1;
    send(1, 5, 4, 0, i2, f);
    chk("R9 issue at producer wb", i2, i1 + 3);
    exp_start(1, i1 + 4, "R9 same-cycle bypass start");
    exp_wb(1, i1 + 9, "R6 mul wb");
    hold_done();
    drain();

    chk("R1 idle ready", int'(dec_ready_o), 1);
    chk("R1 idle wb", int'(wb_o), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=<5000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule